// File: doc/BRIEF.md
# Register-Target Conditional Branch and Link Unit

This block computes the next program counter and the link write for a RISC core whose branches always jump to an address held in a general register. It receives the 32-bit instruction word, the program counter that has already been advanced past the branch, and the values read from the register file for the target and test registers. It decodes the instruction itself, presents the target and test register indices to the register file, and evaluates a three-bit condition code in the low instruction bits against the sign or zero state of the test register.

The unit registers its results on the clock edge that follows the instruction: a taken flag, the next program counter, and a link write (enable, destination index and data). Plain branch and branch-with-link are the only opcodes it acts on. Every other opcode leaves the program counter at its advanced value and writes nothing.

Top module: `brl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs become `br_taken`=0, `next_pc`=0, `link_we`=0, `link_idx`=0 and `link_data`=0.
- R2: The fields are decoded combinationally: opcode = `instr[31:27]`, link index = `instr[26:22]` (driven on `link_idx` one cycle later), target index = `instr[21:17]` on `rb_idx`, test index = `instr[16:12]` on `rc_idx`, condition code = `instr[2:0]`.
- R3: Condition code 0, and the spare codes 6 and 7, never take the branch.
- R4: Condition code 1 always takes the branch.
- R5: Condition code 2 takes the branch when `rc_val` is zero; code 3 takes it when `rc_val` is nonzero.
- R6: Condition code 4 takes the branch when the top bit of `rc_val` is 0; code 5 takes it when that bit is 1.
- R7: One cycle after a branch opcode (8 or 9), `next_pc` equals `rb_val` if taken and `pc_inc` if not.
- R8: One cycle after opcode 9, `link_we`=1 and `link_data`=`pc_inc`, whether or not the branch is taken; with code 0 this is a link with no jump.
- R9: One cycle after opcode 8, `link_we`=0.
- R10: One cycle after any opcode other than 8 or 9, `br_taken`=0, `next_pc`=`pc_inc` and `link_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| pc_inc | input | XLEN | Program counter already advanced past the branch |
| rb_val | input | XLEN | Value of the target register |
| rc_val | input | XLEN | Value of the test register |
| rb_idx | output | 5 | Target register index for the register file read |
| rc_idx | output | 5 | Test register index for the register file read |
| br_taken | output | 1 | Registered branch-taken flag |
| next_pc | output | XLEN | Registered next program counter |
| link_we | output | 1 | Registered link write enable |
| link_idx | output | 5 | Registered link destination index |
| link_data | output | XLEN | Registered link value |

## Verification
The register indices `rb_idx` and `rc_idx` are combinational and are due in the same cycle as the instruction. The taken flag, next PC and link outputs are due exactly one rising edge after the inputs are applied. The bench drives each input on a falling edge and compares all outputs on the next falling edge, half a period after the single register stage has updated. The checker gates its `$past`-based properties with a flag that is set only once a non-reset edge has passed, so a result is never compared against inputs that were applied during reset.

// File: rtl/brl_pkg.sv
package brl_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 5;
    localparam int REG_W   = 5;
    localparam int CFIELD_W = 12;
    localparam int COND_W  = 3;

    localparam logic [OP_W-1:0] OPC_BRANCH = 5'd8;
    localparam logic [OP_W-1:0] OPC_BRLINK = 5'd9;

    typedef enum logic [COND_W-1:0] {
        CC_NEVER  = 3'd0,
        CC_ALWAYS = 3'd1,
        CC_ZERO   = 3'd2,
        CC_NZERO  = 3'd3,
        CC_POS    = 3'd4,
        CC_NEG    = 3'd5,
        CC_RSV6   = 3'd6,
        CC_RSV7   = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_BR   = 2'd1,
        KIND_BRL  = 2'd2
    } kind_e;

    typedef struct packed {
        logic [OP_W-1:0]     op;
        logic [REG_W-1:0]    dst;
        logic [REG_W-1:0]    tgt;
        logic [REG_W-1:0]    tst;
        logic [CFIELD_W-1:0] cfield;
    } fields_t;

    function automatic fields_t split_instr(input logic [INSTR_W-1:0] w);
        fields_t f;
        f.op     = w[31:27];
        f.dst    = w[26:22];
        f.tgt    = w[21:17];
        f.tst    = w[16:12];
        f.cfield = w[11:0];
        return f;
    endfunction

    function automatic kind_e classify(input logic [OP_W-1:0] op);
        kind_e k;
        case (op)
            OPC_BRANCH: k = KIND_BR;
            OPC_BRLINK: k = KIND_BRL;
            default:    k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/brl_decode.sv
module brl_decode
    import brl_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld,
    output kind_e              kind,
    output cond_e              cond
);
    always_comb begin
        fld  = split_instr(instr);
        kind = classify(fld.op);
        cond = cond_e'(fld.cfield[COND_W-1:0]);
    end
endmodule

// File: rtl/brl_cond_eval.sv
module brl_cond_eval
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e            cond,
    input  logic [XLEN-1:0]  rc_val,
    output logic             hit
);
    localparam int SIGN_BIT = XLEN - 1;

    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (rc_val == '0);
        is_neg  = rc_val[SIGN_BIT];
        case (cond)
            CC_ALWAYS: hit = 1'b1;
            CC_ZERO:   hit = is_zero;
            CC_NZERO:  hit = !is_zero;
            CC_POS:    hit = !is_neg;
            CC_NEG:    hit = is_neg;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brl_resolve.sv
module brl_resolve
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e            kind,
    input  logic             hit,
    input  logic [XLEN-1:0]  pc_inc,
    input  logic [XLEN-1:0]  rb_val,
    output logic             take,
    output logic [XLEN-1:0]  npc,
    output logic             lwe,
    output logic [XLEN-1:0]  ldata
);
    always_comb begin
        take  = (kind != KIND_NONE) && hit;
        npc   = take ? rb_val : pc_inc;
        lwe   = (kind == KIND_BRL);
        ldata = lwe ? pc_inc : '0;
    end
endmodule

// File: rtl/brl_unit.sv
module brl_unit
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [XLEN-1:0]      pc_inc,
    input  logic [XLEN-1:0]      rb_val,
    input  logic [XLEN-1:0]      rc_val,
    output logic [REG_W-1:0]     rb_idx,
    output logic [REG_W-1:0]     rc_idx,
    output logic                 br_taken,
    output logic [XLEN-1:0]      next_pc,
    output logic                 link_we,
    output logic [REG_W-1:0]     link_idx,
    output logic [XLEN-1:0]      link_data
);
    fields_t fld;
    kind_e   kind;
    cond_e   cond;
    logic    hit;
    logic    take_c;
    logic    lwe_c;
    logic [XLEN-1:0] npc_c;
    logic [XLEN-1:0] ldata_c;

    brl_decode u_dec (
        .instr (instr),
        .fld   (fld),
        .kind  (kind),
        .cond  (cond)
    );

    brl_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond   (cond),
        .rc_val (rc_val),
        .hit    (hit)
    );

    brl_resolve #(.XLEN(XLEN)) u_res (
        .kind   (kind),
        .hit    (hit),
        .pc_inc (pc_inc),
        .rb_val (rb_val),
        .take   (take_c),
        .npc    (npc_c),
        .lwe    (lwe_c),
        .ldata  (ldata_c)
    );

    assign rb_idx = fld.tgt;
    assign rc_idx = fld.tst;

    always_ff @(posedge clk) begin
        if (rst) begin
            br_taken  <= 1'b0;
            next_pc   <= '0;
            link_we   <= 1'b0;
            link_idx  <= '0;
            link_data <= '0;
        end else begin
            br_taken  <= take_c;
            next_pc   <= npc_c;
            link_we   <= lwe_c;
            link_idx  <= fld.dst;
            link_data <= ldata_c;
        end
    end
endmodule

// File: rtl/brl_unit_chk.sv
module brl_unit_chk
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [INSTR_W-1:0]  instr,
    input logic [XLEN-1:0]     pc_inc,
    input logic [XLEN-1:0]     rb_val,
    input logic [XLEN-1:0]     rc_val,
    input logic [REG_W-1:0]    rb_idx,
    input logic [REG_W-1:0]    rc_idx,
    input logic                br_taken,
    input logic [XLEN-1:0]     next_pc,
    input logic                link_we,
    input logic [REG_W-1:0]    link_idx,
    input logic [XLEN-1:0]     link_data
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!br_taken && !link_we && next_pc == '0));

    assert_index_route_R2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (link_idx == $past(instr[26:22])));

    assert_never_codes_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(instr[2:0]) == 3'd0 || $past(instr[2:0]) >= 3'd6)) |-> !br_taken);

    assert_always_code_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(instr[2:0]) == 3'd1 &&
         ($past(instr[31:27]) == 5'd8 || $past(instr[31:27]) == 5'd9)) |-> br_taken);

    assert_target_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && br_taken) |-> (next_pc == $past(rb_val)));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && !br_taken) |-> (next_pc == $past(pc_inc)));

    assert_link_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(instr[31:27]) == 5'd9) |-> (link_we && link_data == $past(pc_inc)));

    assert_nolink_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(instr[31:27]) == 5'd8) |-> !link_we);

    assert_other_op_R10: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(instr[31:27]) != 5'd8 && $past(instr[31:27]) != 5'd9)
        |-> (!br_taken && !link_we));
endmodule

bind brl_unit brl_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .pc_inc    (pc_inc),
    .rb_val    (rb_val),
    .rc_val    (rc_val),
    .rb_idx    (rb_idx),
    .rc_idx    (rc_idx),
    .br_taken  (br_taken),
    .next_pc   (next_pc),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data)
);

// File: tb/brl_unit_tb.sv
module brl_unit_tb;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc_inc = '0;
    logic [XLEN-1:0] rb_val = '0;
    logic [XLEN-1:0] rc_val = '0;
    logic [4:0]      rb_idx, rc_idx, link_idx;
    logic            br_taken, link_we;
    logic [XLEN-1:0] next_pc, link_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    brl_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .instr(instr), .pc_inc(pc_inc),
        .rb_val(rb_val), .rc_val(rc_val), .rb_idx(rb_idx), .rc_idx(rc_idx),
        .br_taken(br_taken), .next_pc(next_pc), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    function automatic bit exp_take(input logic [31:0] w, input logic [XLEN-1:0] c);
        bit t;
        if (w[31:27] != 5'd8 && w[31:27] != 5'd9) return 1'b0;
        case (w[2:0])
            3'd1: t = 1'b1;
            3'd2: t = (c == 0);
            3'd3: t = (c != 0);
            3'd4: t = !c[XLEN-1];
            3'd5: t = c[XLEN-1];
            default: t = 1'b0;
        endcase
        return t;
    endfunction

    function automatic string req_of(input logic [31:0] w);
        if (w[31:27] != 5'd8 && w[31:27] != 5'd9) return "R10";
        case (w[2:0])
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [4:0] rc,
                                       input logic [11:0] c);
        return {op, ra, rb, rc, c};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [XLEN-1:0] pc,
                         input logic [XLEN-1:0] b, input logic [XLEN-1:0] c);
        bit t;
        bit lk;
        string rq;
        @(negedge clk);
        instr = w; pc_inc = pc; rb_val = b; rc_val = c;
        #1;
        chk("R2", "rb_idx", XLEN'(rb_idx), XLEN'(w[21:17]));
        chk("R2", "rc_idx", XLEN'(rc_idx), XLEN'(w[16:12]));
        t  = exp_take(w, c);
        lk = (w[31:27] == 5'd9);
        rq = req_of(w);
        @(negedge clk);
        chk(rq, "br_taken", XLEN'(br_taken), XLEN'(t));
        chk("R7", "next_pc", next_pc, t ? b : pc);
        chk(lk ? "R8" : (w[31:27] == 5'd8 ? "R9" : "R10"), "link_we",
            XLEN'(link_we), XLEN'(lk));
        if (lk) chk("R8", "link_data", link_data, pc);
        chk("R2", "link_idx", XLEN'(link_idx), XLEN'(w[26:22]));
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] vals [3];
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        vals[0] = 32'h0000_1234;
        vals[1] = 32'h8000_0010;
        vals[2] = 32'h0000_0000;

        instr = mk(5'd8, 5'd3, 5'd4, 5'd5, 12'd1);
        rb_val = 32'hDEAD_BEEF; pc_inc = 32'h44;
        repeat (3) @(negedge clk);
        chk("R1", "br_taken", XLEN'(br_taken), 0);
        chk("R1", "next_pc", next_pc, 0);
        chk("R1", "link_we", XLEN'(link_we), 0);
        chk("R1", "link_data", link_data, 0);
        rst = 1'b0;

        // every code, both branch opcodes, positive/negative/zero test values
        for (int op = 8; op <= 9; op++)
            for (int cc = 0; cc < 8; cc++)
                for (int v = 0; v < 3; v++)
                    apply(mk(5'(op), 5'(cc + 1), 5'(v + 7), 5'(cc + 16), 12'(12'h5a0 | cc)),
                          32'h0000_1000 + 32'(cc * 4), 32'h0002_0000 + 32'(v), vals[v]);

        // R8: link with code 0 is link only
        apply(mk(5'd9, 5'd31, 5'd2, 5'd3, 12'hff8), 32'hFFFF_FFFC, 32'h0, 32'h1);
        // R10: other opcodes, including neighbours of 8 and 9
        apply(mk(5'd7,  5'd1, 5'd2, 5'd3, 12'd1), 32'h200, 32'h999, 32'h0);
        apply(mk(5'd10, 5'd1, 5'd2, 5'd3, 12'd1), 32'h204, 32'h999, 32'h0);
        apply(mk(5'd0,  5'd1, 5'd2, 5'd3, 12'd1), 32'h208, 32'h999, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            logic [XLEN-1:0] c;
            w = $urandom;
            case ($urandom_range(0, 3))
                0: w[31:27] = 5'd8;
                1: w[31:27] = 5'd9;
                default: ;
            endcase
            case ($urandom_range(0, 3))
                0: c = '0;
                1: c = 32'h8000_0000 | $urandom;
                default: c = $urandom;
            endcase
            apply(w, $urandom, $urandom, c);
        end

        // R1: reset again clears outputs
        @(negedge clk);
        rst = 1'b1;
        instr = mk(5'd9, 5'd5, 5'd5, 5'd5, 12'd1);
        @(negedge clk);
        chk("R1", "br_taken", XLEN'(br_taken), 0);
        chk("R1", "link_we", XLEN'(link_we), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule